// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block looks at every interrupt source on behalf of a single processor and decides what, if anything, that processor should be told. Each source arrives with its own state: an enable bit, a pending bit, a group bit, an 8-bit priority and a target mask with one bit per processor. The block takes the sources that qualify and finds the one with the most urgent priority. It then reports that source's identifier as the highest pending interrupt. Finally it decides whether to raise the normal interrupt line, the fast interrupt line, or neither.

Two thresholds gate the decision, one after the other. The priority mask decides whether the winner is reported at all. The running priority then decides whether the reported winner may interrupt the processor. Group enables are applied at two levels, across the whole system and in this processor's own control. A group 0 winner can be steered to the fast line. All outputs are registered, so they follow any change of input state with one clock cycle of latency. Register decoding and the acknowledge and completion flow are handled by neighbouring logic.

Top module: `intsel_cpu`

## Requirements
- R1: A source qualifies only when its enable and pending bits are both 1. It must also either have an identifier below 32 (private source, target mask ignored) or have bit CPU_IDX set in its CPU_W-bit slice of the target mask.
- R2: Among the qualifying sources, the one with the numerically smallest priority wins. When priorities are equal, the source with the lower identifier wins.
- R3: When no source qualifies, the pending identifier is 1023 and both interrupt outputs are 0.
- R4: When both system group enable bits are 0, or both per-CPU group enable bits are 0, both outputs are 0 and the pending identifier is 1023.
- R5: The winner's identifier is reported only when its priority is strictly below the priority mask. Otherwise the identifier is 1023 and both outputs are 0.
- R6: An output is raised only when the winner's priority is also strictly below the 9-bit running priority. The value 0x100 means that nothing is running.
- R7: An output is raised only when the winner's group has its enable bit set both in the system group enable (bit 0 = group 0, bit 1 = group 1) and in the per-CPU group enable.
- R8: When an output is raised, a group 0 winner with the fast-enable input at 1 drives the fast line. Every other winner drives the normal line.
- R9: All outputs are registered and change one clock edge after the input change that causes them.
- R10: While reset is asserted (asynchronous, active low), both outputs are 0 and the pending identifier is 1023.
- R11: The normal line and the fast line are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_enable | input | NUM_SRC | Per-source enable |
| src_pending | input | NUM_SRC | Per-source pending |
| src_group | input | NUM_SRC | Per-source group (0 or 1) |
| src_prio | input | NUM_SRC*8 | Per-source priority, source i at bits [8i+7:8i] |
| src_target | input | NUM_SRC*CPU_W | Per-source target mask, source i at bits [CPU_W*i+CPU_W-1:CPU_W*i] |
| sys_grp_en | input | 2 | System-wide group enables |
| cpu_grp_en | input | 2 | Group enables of this processor |
| cpu_fast_en | input | 1 | Route group 0 winners to the fast line |
| prio_mask | input | 8 | Priority mask for reporting |
| run_prio | input | 9 | Running priority of this processor |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| pend_id | output | 10 | Highest pending identifier, 1023 if none |

## Verification
The bench checks both sides of each strict threshold. A priority equal to the mask or to the running priority must not pass; a design using less-or-equal would report or raise an interrupt one level too early. Equal priorities must resolve to the lower identifier; a tree that keeps the right-hand operand on a tie would report the higher source. A shared source without this processor's target bit is tested, along with a private source whose mask is empty. A design that ignored the target mask, or applied it to private sources, would pick the wrong winner. The bench also covers a winner whose own group is disabled while the other group stays enabled, and the fast routing for both groups.

// File: rtl/intsel_pkg.sv
package intsel_pkg;
  localparam int ID_W       = 10;
  localparam int PRIO_W     = 8;
  localparam int PRIV_LIMIT = 32;
  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W:0]   IDLE_PRIO   = 9'h100;

  // One candidate as seen by the comparator tree; prio is one bit wider so
  // an empty slot can hold a value no real priority reaches.
  typedef struct packed {
    logic [PRIO_W:0] prio;
    logic [ID_W-1:0] id;
    logic            grp;
  } cand_t;

  localparam cand_t NO_CAND = '{prio: IDLE_PRIO, id: SPURIOUS_ID, grp: 1'b0};
endpackage

// File: rtl/intsel_qualify.sv
module intsel_qualify
  import intsel_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int CPU_W   = 8,
  parameter int CPU_IDX = 0
) (
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC-1:0]        src_pending,
  input  logic [NUM_SRC-1:0]        src_group,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [NUM_SRC*CPU_W-1:0]  src_target,
  output cand_t                     leaf [NUM_SRC]
);
  logic unused_tgt;
  assign unused_tgt = ^src_target;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic routed;
    if (i < PRIV_LIMIT) begin : g_priv
      assign routed = 1'b1;
    end else begin : g_shared
      assign routed = src_target[i*CPU_W + CPU_IDX];
    end

    always_comb begin
      if (src_enable[i] && src_pending[i] && routed) begin
        leaf[i].prio = {1'b0, src_prio[i*PRIO_W +: PRIO_W]};
        leaf[i].id   = ID_W'(i);
        leaf[i].grp  = src_group[i];
      end else begin
        leaf[i] = NO_CAND;
      end
    end
  end
endmodule

// File: rtl/intsel_tree.sv
module intsel_tree
  import intsel_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  cand_t leaf [NUM_SRC],
  output cand_t best
);
  localparam int LVLS  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
  localparam int SLOTS = 1 << LVLS;
  localparam int NODES = 2 * SLOTS - 1;

  cand_t node [NODES];

  // Heap layout: leaves at SLOTS-1.., left child always covers lower ids,
  // so keeping the left operand on a tie keeps the lower-numbered source.
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      if (i < NUM_SRC) node[SLOTS-1+i] = leaf[i];
      else             node[SLOTS-1+i] = NO_CAND;
    end
    for (int k = SLOTS - 2; k >= 0; k--) begin
      if (node[2*k+2].prio < node[2*k+1].prio) node[k] = node[2*k+2];
      else                                     node[k] = node[2*k+1];
    end
  end

  assign best = node[0];

  // R2
  always_comb begin
    best_range_chk: assert ((best.prio == IDLE_PRIO) || (int'(best.id) < NUM_SRC))
      else $error("winner identifier outside source range");
  end
endmodule

// File: rtl/intsel_gate.sv
module intsel_gate
  import intsel_pkg::*;
(
  input  cand_t           best,
  input  logic [1:0]      sys_grp_en,
  input  logic [1:0]      cpu_grp_en,
  input  logic            cpu_fast_en,
  input  logic [PRIO_W-1:0] prio_mask,
  input  logic [PRIO_W:0] run_prio,
  output logic            nxt_irq,
  output logic            nxt_fiq,
  output logic [ID_W-1:0] nxt_id
);
  logic any_grp;
  logic below_mask;
  logic below_run;
  logic grp_ok;

  assign any_grp    = (|sys_grp_en) && (|cpu_grp_en);
  assign below_mask = best.prio < {1'b0, prio_mask};
  assign below_run  = best.prio < run_prio;
  assign grp_ok     = sys_grp_en[best.grp] && cpu_grp_en[best.grp];

  always_comb begin
    nxt_irq = 1'b0;
    nxt_fiq = 1'b0;
    nxt_id  = SPURIOUS_ID;
    if (any_grp && below_mask) begin
      nxt_id = best.id;
      if (below_run && grp_ok) begin
        if (!best.grp && cpu_fast_en) nxt_fiq = 1'b1;
        else                          nxt_irq = 1'b1;
      end
    end
  end

  // R11
  always_comb begin
    next_one_line_chk: assert (!(nxt_irq && nxt_fiq))
      else $error("both lines selected");
  end
endmodule

// File: rtl/intsel_cpu.sv
module intsel_cpu
  import intsel_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int CPU_W   = 8,
  parameter int CPU_IDX = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC-1:0]        src_pending,
  input  logic [NUM_SRC-1:0]        src_group,
  input  logic [NUM_SRC*8-1:0]      src_prio,
  input  logic [NUM_SRC*CPU_W-1:0]  src_target,
  input  logic [1:0]                sys_grp_en,
  input  logic [1:0]                cpu_grp_en,
  input  logic                      cpu_fast_en,
  input  logic [7:0]                prio_mask,
  input  logic [8:0]                run_prio,
  output logic                      irq_o,
  output logic                      fiq_o,
  output logic [9:0]                pend_id
);
  cand_t           leaf [NUM_SRC];
  cand_t           best;
  logic            nxt_irq;
  logic            nxt_fiq;
  logic [ID_W-1:0] nxt_id;
  logic            upd_en;
  logic            irq_q;
  logic            fiq_q;
  logic [ID_W-1:0] id_q;

  intsel_qualify #(.NUM_SRC(NUM_SRC), .CPU_W(CPU_W), .CPU_IDX(CPU_IDX)) u_qual (
    .src_enable  (src_enable),
    .src_pending (src_pending),
    .src_group   (src_group),
    .src_prio    (src_prio),
    .src_target  (src_target),
    .leaf        (leaf)
  );

  intsel_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .leaf (leaf),
    .best (best)
  );

  intsel_gate u_gate (
    .best        (best),
    .sys_grp_en  (sys_grp_en),
    .cpu_grp_en  (cpu_grp_en),
    .cpu_fast_en (cpu_fast_en),
    .prio_mask   (prio_mask),
    .run_prio    (run_prio),
    .nxt_irq     (nxt_irq),
    .nxt_fiq     (nxt_fiq),
    .nxt_id      (nxt_id)
  );

  // Clock enable: registers only toggle when the decision moves.
  always_comb begin
    upd_en = (nxt_irq != irq_q) || (nxt_fiq != fiq_q) || (nxt_id != id_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
      id_q  <= SPURIOUS_ID;
    end else if (upd_en) begin
      irq_q <= nxt_irq;
      fiq_q <= nxt_fiq;
      id_q  <= nxt_id;
    end
  end

  assign irq_o   = irq_q;
  assign fiq_o   = fiq_q;
  assign pend_id = id_q;

  // R11
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));

  // R4
  grp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|sys_grp_en) || !(|cpu_grp_en)) |=> (!irq_o && !fiq_o && pend_id == SPURIOUS_ID));

  // R8
  fast_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(cpu_fast_en));

  // R5
  line_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> (pend_id != SPURIOUS_ID));
endmodule

// File: tb/tb_intsel_cpu.sv
module tb_intsel_cpu;
  localparam int NS = 40;
  localparam int CW = 4;
  localparam int CI = 1;
  localparam logic [5:0] NONE = 6'd63;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0]    en, pend, grp;
  logic [NS*8-1:0]  prio;
  logic [NS*CW-1:0] tgt;
  logic [1:0] sge, cge;
  logic       fen;
  logic [7:0] mask;
  logic [8:0] run;
  logic       irq_o, fiq_o;
  logic [9:0] pend_id;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  intsel_cpu #(.NUM_SRC(NS), .CPU_W(CW), .CPU_IDX(CI)) dut (
    .clk(clk), .rst_n(rst_n),
    .src_enable(en), .src_pending(pend), .src_group(grp),
    .src_prio(prio), .src_target(tgt),
    .sys_grp_en(sge), .cpu_grp_en(cge), .cpu_fast_en(fen),
    .prio_mask(mask), .run_prio(run),
    .irq_o(irq_o), .fiq_o(fiq_o), .pend_id(pend_id)
  );

  typedef struct packed {
    logic [5:0] aid; logic [7:0] ap; logic ag; logic [3:0] at;
    logic [5:0] bid; logic [7:0] bp; logic bg; logic [3:0] bt;
    logic [1:0] dg; logic [1:0] cg; logic fe; logic [7:0] mk; logic [8:0] rp;
    logic xi; logic xf; logic [9:0] xid; logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    // R2 lower priority wins
    '{6'd5, 8'h40, 1'b1, 4'h2, 6'd9, 8'h20, 1'b1, 4'h2, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b1, 1'b0, 10'd9, 4'd2},
    // R2 tie keeps lower id
    '{6'd3, 8'h30, 1'b1, 4'h2, 6'd7, 8'h30, 1'b1, 4'h2, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b1, 1'b0, 10'd3, 4'd2},
    // R1 shared source without this CPU's bit is dropped
    '{6'd35, 8'h10, 1'b1, 4'h1, 6'd36, 8'h50, 1'b1, 4'h2, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b1, 1'b0, 10'd36, 4'd1},
    // R1 private source ignores an empty mask
    '{6'd20, 8'h10, 1'b1, 4'h0, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b1, 1'b0, 10'd20, 4'd1},
    // R5 priority equal to mask is hidden
    '{6'd4, 8'h80, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b0, 8'h80, 9'h100, 1'b0, 1'b0, 10'd1023, 4'd5},
    // R5 one below mask is shown
    '{6'd4, 8'h7F, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b0, 8'h80, 9'h100, 1'b1, 1'b0, 10'd4, 4'd5},
    // R6 equal to running priority: id reported, no line
    '{6'd4, 8'h40, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h040, 1'b0, 1'b0, 10'd4, 4'd6},
    // R6 one below running priority raises
    '{6'd4, 8'h40, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h041, 1'b1, 1'b0, 10'd4, 4'd6},
    // R8 group 0 with fast enable
    '{6'd4, 8'h40, 1'b0, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b1, 8'hFF, 9'h100, 1'b0, 1'b1, 10'd4, 4'd8},
    // R8 group 0 without fast enable
    '{6'd4, 8'h40, 1'b0, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b1, 1'b0, 10'd4, 4'd8},
    // R8 group 1 ignores fast enable
    '{6'd4, 8'h40, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b1, 8'hFF, 9'h100, 1'b1, 1'b0, 10'd4, 4'd8},
    // R7 group 1 off system-wide
    '{6'd4, 8'h40, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd1, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 10'd4, 4'd7},
    // R7 group 1 off for this CPU
    '{6'd4, 8'h40, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd1, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 10'd4, 4'd7},
    // R4 no system groups
    '{6'd4, 8'h40, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd0, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 10'd1023, 4'd4},
    // R4 no CPU groups
    '{6'd4, 8'h40, 1'b1, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd0, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 10'd1023, 4'd4},
    // R3 no candidates
    '{NONE, 8'h00, 1'b0, 4'h0, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 10'd1023, 4'd3},
    // R2 highest id with priority 0 beats id 0
    '{6'd0, 8'hFE, 1'b1, 4'h2, 6'd39, 8'h00, 1'b1, 4'h2, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b1, 1'b0, 10'd39, 4'd2},
    // R7 group 0 winner, CPU enables only group 1
    '{6'd4, 8'h40, 1'b0, 4'h2, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd2, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 10'd4, 4'd7},
    // R1 shared source with other CPUs' bits only
    '{6'd38, 8'h10, 1'b1, 4'hD, NONE, 8'h00, 1'b0, 4'h0, 2'd3, 2'd3, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 10'd1023, 4'd1},
    // R2 cross-group tie, lower id group 0 goes fast
    '{6'd2, 8'h10, 1'b0, 4'h2, 6'd30, 8'h10, 1'b1, 4'h2, 2'd3, 2'd3, 1'b1, 8'hFF, 9'h100, 1'b0, 1'b1, 10'd2, 4'd2}
  };

  task automatic clear_src();
    en = '0; pend = '0; grp = '0; prio = '0; tgt = '0;
  endtask

  task automatic put_src(input logic [5:0] id, input logic [7:0] p,
                         input logic g, input logic [3:0] t);
    if (id != NONE) begin
      en[id] = 1'b1; pend[id] = 1'b1; grp[id] = g;
      prio[id*8 +: 8] = p; tgt[id*CW +: CW] = t;
    end
  endtask

  task automatic apply(input vec_t v);
    clear_src();
    put_src(v.aid, v.ap, v.ag, v.at);
    put_src(v.bid, v.bp, v.bg, v.bt);
    sge = v.dg; cge = v.cg; fen = v.fe; mask = v.mk; run = v.rp;
  endtask

  task automatic check(input string tag, input logic xi, input logic xf,
                       input logic [9:0] xid);
    checks++;
    if (irq_o !== xi || fiq_o !== xf || pend_id !== xid) begin
      errors++;
      $display("FAIL %s: irq=%0b fiq=%0b id=%0d expected irq=%0b fiq=%0b id=%0d",
               tag, irq_o, fiq_o, pend_id, xi, xf, xid);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_src();
    sge = 2'd3; cge = 2'd3; fen = 1'b0; mask = 8'hFF; run = 9'h100;
    put_src(6'd1, 8'h10, 1'b1, 4'h2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset state", 1'b0, 1'b0, 10'd1023);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].xi, VEC[i].xf, VEC[i].xid);
    end

    // R1 enabled but not pending, then pending but not enabled
    @(negedge clk);
    apply(VEC[0]);
    pend[9] = 1'b0; pend[5] = 1'b0;
    @(negedge clk);
    check("R1 not pending", 1'b0, 1'b0, 10'd1023);
    apply(VEC[0]);
    en[9] = 1'b0;
    @(negedge clk);
    check("R1 not enabled", 1'b1, 1'b0, 10'd5);

    // R9 one cycle of latency
    apply(VEC[0]);
    @(negedge clk);
    check("R9 settled", 1'b1, 1'b0, 10'd9);
    apply(VEC[15]);
    #1;
    check("R9 before edge", 1'b1, 1'b0, 10'd9);
    @(negedge clk);
    check("R9 after edge", 1'b0, 1'b0, 10'd1023);

    // R10 asynchronous reset mid-run
    apply(VEC[8]);
    @(negedge clk);
    check("R8 fast before reset", 1'b0, 1'b1, 10'd4);
    #2 rst_n = 1'b0;
    #1;
    check("R10 async reset", 1'b0, 1'b0, 10'd1023);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 1'b0, 1'b1, 10'd4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule